// File: doc/BRIEF.md
# Serial-Loaded Latched Open-Drain Output Register

This block is a shift register with serial input and parallel output. It has a separate storage stage and models open-drain outputs. On each rising edge of the shift clock, a serial bit enters the first stage, and every other stage takes the value of the stage before it. A storage control input opens a level-sensitive latch. While that input is high, the storage stage follows the shift chain. While it is low, the storage stage holds its value. The stored bits drive a bank of pull-down enables. Each output bit means "transistor on, line pulled low". A stored 0 pulls its line low and a stored 1 leaves the line to its external pull-up. A disable input turns every pull-down off.

The last shift stage is presented on a cascade output, updated on the falling edge of the shift clock. This output is independent of the disable input, so a second register can be chained directly. To load a full word, clock in STAGES bits with the first bit sent ending in the highest stage, then pulse the storage control. An active-low asynchronous reset clears the chain, the storage stage and the cascade output.

Top module: `od_latch_shifter`

## Requirements
- R1: On each rising edge of `clk_i` out of reset, stage 0 takes `ser_i` and stage i takes the previous value of stage i-1. Stage i corresponds to output bit i.
- R2: Shifting while `strobe_i` is low leaves `pull_lo_o` unchanged.
- R3: While `strobe_i` is high, the storage stage is transparent: it follows the shift chain, including across shifts.
- R4: While `strobe_i` is low, the storage stage holds the value it had when `strobe_i` fell.
- R5: While `drive_off_i` is high, every bit of `pull_lo_o` is 0.
- R6: While `drive_off_i` is low, `pull_lo_o[i]` is the inverse of stored bit i (1 means pulled low).
- R7: `casc_o` takes the value of the last stage on each falling edge of `clk_i`, regardless of `drive_off_i`.
- R8: After STAGES rising edges followed by a `strobe_i` pulse, the first bit shifted appears at `pull_lo_o[STAGES-1]` and the last bit shifted at `pull_lo_o[0]`.
- R9: `rst_ni` low asynchronously clears the chain, the storage stage and `casc_o` to 0. With `drive_off_i` low, every `pull_lo_o` bit then reads 1.
- R10: Feeding `casc_o` into the `ser_i` of a second instance on the same clock forms a 2*STAGES chain, and a 2*STAGES-bit pattern loads correctly across both instances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock; chain moves on the rising edge, cascade output updates on the falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_i | input | 1 | Serial data into stage 0 |
| strobe_i | input | 1 | Storage control; high = latch transparent, low = hold |
| drive_off_i | input | 1 | High turns every output pull-down off |
| pull_lo_o | output | STAGES | Pull-down enables; 1 = line driven low |
| casc_o | output | 1 | Last shift stage, for cascading |

## Verification
The bench builds two instances at the default STAGES of 12 and chains them through the cascade output, giving a 24-bit path. This exercises the falling-edge cascade timing under a real downstream consumer. It also allows a 24-bit directed load that confirms bit ordering end to end. The shift clock is gated so that the storage control can be pulsed with no shift in between. This separates latch transparency during shifting from a plain transfer, and lets a mid-run asynchronous reset land while the clock is idle.

// File: rtl/od_latch_pkg.sv
package od_latch_pkg;
   localparam int unsigned OD_STAGES_DEFAULT = 12;
   localparam int unsigned OD_STAGES_MIN     = 2;

   // A stored 0 turns the pull-down on unless the bank is disabled.
   function automatic logic od_pull(input logic stored, input logic off);
      return ~off & ~stored;
   endfunction
endpackage

// File: rtl/od_shift_chain.sv
module od_shift_chain #(
   parameter int unsigned STAGES = od_latch_pkg::OD_STAGES_DEFAULT
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ser_i,
   output logic [STAGES-1:0] q_o,
   output logic              casc_o
);
   localparam int unsigned LAST = STAGES - 1;

   logic [STAGES-1:0] stage_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q <= '0;
      else         stage_q <= {stage_q[LAST-1:0], ser_i};
   end

   // Cascade bit moves on the opposite edge so a downstream chain on the same clock has half a period of hold margin.
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) casc_o <= 1'b0;
      else         casc_o <= stage_q[LAST];
   end

   assign q_o = stage_q;
endmodule

// File: rtl/od_store_latch.sv
module od_store_latch #(
   parameter int unsigned STAGES = od_latch_pkg::OD_STAGES_DEFAULT
) (
   input  logic              rst_ni,
   input  logic              open_i,
   input  logic [STAGES-1:0] d_i,
   output logic [STAGES-1:0] q_o
);
   always_latch begin
      if (!rst_ni)     q_o <= '0;
      else if (open_i) q_o <= d_i;
   end
endmodule

// File: rtl/od_pulldown_bank.sv
module od_pulldown_bank #(
   parameter int unsigned STAGES = od_latch_pkg::OD_STAGES_DEFAULT
) (
   input  logic [STAGES-1:0] store_i,
   input  logic              off_i,
   output logic [STAGES-1:0] pull_o
);
   for (genvar g = 0; g < STAGES; g++) begin : g_cell
      assign pull_o[g] = od_latch_pkg::od_pull(store_i[g], off_i);
   end
endmodule

// File: rtl/od_latch_shifter.sv
module od_latch_shifter #(
   parameter int unsigned STAGES = od_latch_pkg::OD_STAGES_DEFAULT
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ser_i,
   input  logic              strobe_i,
   input  logic              drive_off_i,
   output logic [STAGES-1:0] pull_lo_o,
   output logic              casc_o
);
   if (STAGES < od_latch_pkg::OD_STAGES_MIN) begin : g_bad_stages
      $error("od_latch_shifter: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic [STAGES-1:0] store_q;

   od_shift_chain #(.STAGES(STAGES)) u_chain (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ser_i  (ser_i),
      .q_o    (chain_q),
      .casc_o (casc_o)
   );

   od_store_latch #(.STAGES(STAGES)) u_store (
      .rst_ni (rst_ni),
      .open_i (strobe_i),
      .d_i    (chain_q),
      .q_o    (store_q)
   );

   od_pulldown_bank #(.STAGES(STAGES)) u_bank (
      .store_i (store_q),
      .off_i   (drive_off_i),
      .pull_o  (pull_lo_o)
   );
endmodule

// File: rtl/od_latch_shifter_chk.sv
module od_latch_shifter_chk #(
   parameter int unsigned STAGES = od_latch_pkg::OD_STAGES_DEFAULT
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              ser_i,
   input logic              strobe_i,
   input logic              drive_off_i,
   input logic [STAGES-1:0] pull_lo_o,
   input logic              casc_o,
   input logic [STAGES-1:0] chain_q,
   input logic [STAGES-1:0] store_q
);
   // Set once a rising edge has been taken out of reset, so $past refers to a real shift.
   logic armed;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) armed <= 1'b0;
      else         armed <= 1'b1;
   end

   assert_shift_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed |-> chain_q == {$past(chain_q[STAGES-2:0]), $past(ser_i)});

   assert_transparent_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
      strobe_i |-> store_q == chain_q);

   assert_disabled_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
      drive_off_i |-> pull_lo_o == '0);

   assert_drive_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
      !drive_off_i |-> pull_lo_o == ~store_q);

   assert_casc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      casc_o == chain_q[STAGES-1]);
endmodule

bind od_latch_shifter od_latch_shifter_chk #(.STAGES(STAGES)) u_chk (.*);

// File: tb/od_latch_shifter_test.sv
`timescale 1ns/100ps
module od_latch_shifter_test;
   localparam int N = 12;
   localparam int W = 2 * N;

   logic clk = 1'b0, run = 1'b0, rst_n = 1'b0;
   logic ser = 1'b0, strobe = 1'b0, off = 1'b0;
   logic sclk;
   logic [N-1:0] pl_a, pl_b;
   logic casc_a, casc_b;

   always #2.5 clk = ~clk;
   assign sclk = clk & run;

   od_latch_shifter #(.STAGES(N)) uut (
      .clk_i(sclk), .rst_ni(rst_n), .ser_i(ser), .strobe_i(strobe),
      .drive_off_i(off), .pull_lo_o(pl_a), .casc_o(casc_a));

   od_latch_shifter #(.STAGES(N)) u_tail (
      .clk_i(sclk), .rst_ni(rst_n), .ser_i(casc_a), .strobe_i(strobe),
      .drive_off_i(off), .pull_lo_o(pl_b), .casc_o(casc_b));

   logic [W-1:0] m_chain = '0, m_store = '0;
   logic m_off = 1'b0, m_strobe = 1'b0;
   int vectors = 0, miscompares = 0;
   bit done = 1'b0;

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [N-1:0] exp_pull(input logic [N-1:0] st, input logic o);
      return o ? '0 : ~st;
   endfunction

   task automatic check_all();
      string t;
      t = m_off ? "R5" : (m_strobe ? "R1/R3/R6" : "R2/R4/R6");
      chk({t, " head outputs"}, pl_a, exp_pull(m_store[N-1:0], m_off));
      chk({t, "/R10 tail outputs"}, pl_b, exp_pull(m_store[W-1:N], m_off));
      chk("R7 head cascade", {{(N-1){1'b0}}, casc_a}, {{(N-1){1'b0}}, m_chain[N-1]});
      chk("R7/R10 tail cascade", {{(N-1){1'b0}}, casc_b}, {{(N-1){1'b0}}, m_chain[W-1]});
   endtask

   task automatic cycle(input logic d, input logic s, input logic o, input logic sh);
      @(negedge clk);
      #0.5 check_all();
      #0.5;
      ser = d; strobe = s; off = o; run = sh;
      m_off = o; m_strobe = s;
      if (s) m_store = m_chain;
      @(posedge clk);
      if (sh) begin
         m_chain = {m_chain[W-2:0], d};
         if (s) m_store = m_chain;
      end
   endtask

   task automatic mid_reset();
      @(negedge clk);
      #1 run = 1'b0; strobe = 1'b0; off = 1'b0;
      m_strobe = 1'b0; m_off = 1'b0;
      rst_n = 1'b0; m_chain = '0; m_store = '0;
      #1;
      chk("R9 head cleared", pl_a, {N{1'b1}});
      chk("R9 tail cleared", pl_b, {N{1'b1}});
      chk("R9 cascade cleared", {{(N-2){1'b0}}, casc_b, casc_a}, '0);
      @(negedge clk);
      #1 rst_n = 1'b1;
   endtask

   initial begin
      logic [W-1:0] pat;
      void'($urandom(32'h00C0_FFEE));
      #6;
      chk("R9 reset head", pl_a, {N{1'b1}});
      chk("R9 reset tail", pl_b, {N{1'b1}});
      chk("R9 reset cascade", {{(N-2){1'b0}}, casc_b, casc_a}, '0);
      @(negedge clk);
      #1 rst_n = 1'b1;

      // Full 24-bit load with storage closed, then a transfer pulse with no shift.
      pat = 24'hA5_C3_96;
      for (int i = W - 1; i >= 0; i--) cycle(pat[i], 1'b0, 1'b0, 1'b1);
      cycle(1'b0, 1'b1, 1'b0, 1'b0);
      cycle(1'b0, 1'b0, 1'b0, 1'b0);
      chk("R8/R10 head load", pl_a, ~pat[N-1:0]);
      chk("R8/R10 tail load", pl_b, ~pat[W-1:N]);
      chk("R8 first bit at top", {{(N-1){1'b0}}, pl_b[N-1]}, {{(N-1){1'b0}}, ~pat[W-1]});

      // Outputs disabled while shifting; cascade keeps moving.
      for (int i = 0; i < 6; i++) cycle(i[0], 1'b0, 1'b1, 1'b1);
      // Transparency while shifting.
      for (int i = 0; i < N; i++) cycle(i[1], 1'b1, 1'b0, 1'b1);
      // Hold while shifting.
      for (int i = 0; i < N; i++) cycle(~i[0], 1'b0, 1'b0, 1'b1);
      // Walking one, then latch.
      cycle(1'b1, 1'b0, 1'b0, 1'b1);
      for (int i = 0; i < N - 1; i++) cycle(1'b0, 1'b0, 1'b0, 1'b1);
      cycle(1'b0, 1'b1, 1'b0, 1'b0);
      cycle(1'b0, 1'b0, 1'b0, 1'b0);

      mid_reset();

      for (int i = 0; i < 400; i++) begin
         logic d, s, o, sh;
         d  = $urandom() % 2;
         s  = ($urandom() % 5) == 0;
         o  = ($urandom() % 4) == 0;
         sh = ($urandom() % 5) != 0;
         cycle(d, s, o, sh);
         if (i == 200) mid_reset();
      end
      cycle(1'b0, 1'b0, 1'b0, 1'b0);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule